// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Timed Refresh

This block sits between a simple word-request port and an asynchronous DRAM whose address pins carry the row and the column at different times. For each request it places the row half of the address on the shared lines, asserts the active-low row strobe, and then presents the column half and asserts the active-low column strobe. For writes it drives the data bus and pulls write enable low for the whole column phase. For reads it samples the data bus after the column strobe has been low for a set number of cycles, and returns the word with a one-cycle valid pulse.

After an access completes, the row strobe stays asserted, so the row remains open as a page. A later request to the same row goes straight to the column phase. A request to a different row first releases the row strobe for a precharge interval. A free-running timer raises a refresh request once per period. The request is served as soon as the current access finishes. It closes any open page and activates the next row in sequence with the column strobe held high. Requests are not accepted while a refresh is pending or running.

Top module: `page_dram_ctrl`

## Requirements
- R1: During reset both strobes and write enable are high (inactive), the data bus is not driven and no read response is signalled.
- R2: The row address is on the address lines one cycle before the row strobe falls and does not change on the edge where it falls.
- R3: The column strobe falls only while the row strobe is low, and the address lines do not change on the edge where it falls.
- R4: A read returns the data most recently written to the same row/column address. The request address is {row, column}, with the row in the upper bits.
- R5: Read latency, counted in clock edges from the accepting edge to the edge after which the response valid is high, is ACC_CYC+1 when the requested row is already open, ACC_CYC+3 when no row is open, and ACC_CYC+3+PRE_CYC when a different row is open.
- R6: Between any rise of the row strobe and its next fall, the row strobe stays high for at least PRE_CYC cycles.
- R7: Every row is activated, by refresh or by an access, at least once in every ROWS*REF_PERIOD cycles plus a small bounded delay. A pending refresh is only served after the access in progress has finished.
- R8: Each refresh activates exactly one row, with the column strobe kept high. Successive refreshes use successive row addresses, wrapping from the last row back to row 0.
- R9: The response valid is high for one cycle per read and is never high on two consecutive cycles.
- R10: Ready goes low on the cycle after a request is accepted and stays low until that access is finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Word address {row, column} |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | DATA_W | Read data |
| mem_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_row_sel_n_o | output | 1 | Row strobe, active low |
| mem_col_sel_n_o | output | 1 | Column strobe, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_dq_o | output | DATA_W | Data to the DRAM |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W | Data from the DRAM |

## Verification
The bench builds the controller with ROW_W=3, COL_W=3, DATA_W=8, PRE_CYC=2 and ACC_CYC=2, so the whole 64-word array can be written and read back in several orders: row-major, where most reads hit the open page; column-major, where every read misses; and a scrambled mixed read/write order. REF_PERIOD=60 makes refresh fall between requests every few accesses. Because of this, the bench sees the page-closed latency case, the wrap of the refresh row sequence and the per-row refresh deadline many times in a short run. A long idle stretch shows that refresh keeps running without traffic.

// File: rtl/page_dram_pkg.sv
package page_dram_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_ROW_SET, ST_ROW_HOLD, ST_COL_SET,
    ST_COL_ACT, ST_RSP, ST_REF_SET, ST_REF_ACT
  } ctrl_st_e;

  typedef enum logic [1:0] {TGT_ROW, TGT_REF, TGT_IDLE} pre_tgt_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_wait_cnt.sv
module dram_wait_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int PERIOD = 1562,
  parameter int ROW_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             done_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0]    cnt_q;
  logic             pend_q;
  logic [ROW_W-1:0] row_q;
  logic             wrap;

  assign wrap = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)        pend_q <= 1'b1;
      else if (take_i) pend_q <= 1'b0;
      if (done_i)      row_q  <= row_q + 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign row_o  = row_q;

  // R7
  take_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pend_q);
endmodule

// File: rtl/page_dram_ctrl.sv
module page_dram_ctrl
  import page_dram_pkg::*;
#(
  parameter int ROW_W      = 10,
  parameter int COL_W      = 8,
  parameter int DATA_W     = 16,
  parameter int REF_PERIOD = 1562,
  parameter int PRE_CYC    = 2,
  parameter int ACC_CYC    = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_we_i,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic                   rsp_valid_o,
  output logic [DATA_W-1:0]      rsp_rdata_o,
  output logic [max_i(ROW_W,COL_W)-1:0] mem_addr_o,
  output logic                   mem_row_sel_n_o,
  output logic                   mem_col_sel_n_o,
  output logic                   mem_we_n_o,
  output logic [DATA_W-1:0]      mem_dq_o,
  output logic                   mem_dq_oe_o,
  input  logic [DATA_W-1:0]      mem_dq_i
);
  localparam int AW  = max_i(ROW_W, COL_W);
  localparam int WW  = $clog2(max_i(PRE_CYC, ACC_CYC) + 1);
  localparam int HW  = $clog2(PRE_CYC + 2);

  ctrl_st_e          st_q, st_d;
  pre_tgt_e          tgt_q, tgt_d;
  logic [ROW_W-1:0]  row_q, open_row_q, ref_row;
  logic [COL_W-1:0]  col_q;
  logic              we_q, page_open_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              ld, wait_zero, ref_pend, ref_take, ref_done;
  logic [WW-1:0]     ld_val;
  logic              accept, row_active;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;

  assign req_row = req_addr_i[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr_i[COL_W-1:0];
  assign req_ready_o = (st_q == ST_IDLE) && !ref_pend;
  assign accept = req_valid_i && req_ready_o;

  dram_wait_cnt #(.W(WW)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld), .val_i(ld_val), .zero_o(wait_zero)
  );

  dram_ref_timer #(.PERIOD(REF_PERIOD), .ROW_W(ROW_W)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(ref_take), .done_i(ref_done),
    .pend_o(ref_pend), .row_o(ref_row)
  );

  always_comb begin
    st_d     = st_q;
    tgt_d    = tgt_q;
    ld       = 1'b0;
    ld_val   = '0;
    ref_take = 1'b0;
    ref_done = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend) begin
          st_d = ST_PRE; tgt_d = TGT_REF; ref_take = 1'b1;
          ld = 1'b1; ld_val = WW'(PRE_CYC - 1);
        end else if (req_valid_i) begin
          if (page_open_q && open_row_q == req_row) begin
            st_d = ST_COL_SET;
          end else if (page_open_q) begin
            st_d = ST_PRE; tgt_d = TGT_ROW;
            ld = 1'b1; ld_val = WW'(PRE_CYC - 1);
          end else begin
            st_d = ST_ROW_SET;
          end
        end
      end
      ST_PRE: if (wait_zero) begin
        unique case (tgt_q)
          TGT_REF:  st_d = ST_REF_SET;
          TGT_ROW:  st_d = ST_ROW_SET;
          default:  st_d = ST_IDLE;
        endcase
      end
      ST_ROW_SET:  st_d = ST_ROW_HOLD;
      ST_ROW_HOLD: st_d = ST_COL_SET;
      ST_COL_SET: begin
        st_d = ST_COL_ACT; ld = 1'b1; ld_val = WW'(ACC_CYC - 1);
      end
      ST_COL_ACT:  if (wait_zero) st_d = ST_RSP;
      ST_RSP:      st_d = ST_IDLE;
      ST_REF_SET: begin
        st_d = ST_REF_ACT; ld = 1'b1; ld_val = WW'(ACC_CYC - 1);
      end
      ST_REF_ACT: if (wait_zero) begin
        st_d = ST_PRE; tgt_d = TGT_IDLE; ref_done = 1'b1;
        ld = 1'b1; ld_val = WW'(PRE_CYC - 1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      tgt_q       <= TGT_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      open_row_q  <= '0;
      page_open_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
      if (accept) begin
        row_q   <= req_row;
        col_q   <= req_col;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      if (st_d == ST_PRE && st_q != ST_PRE) page_open_q <= 1'b0;
      if (st_q == ST_ROW_SET) begin
        page_open_q <= 1'b1;
        open_row_q  <= row_q;
      end
      if (st_q == ST_COL_ACT && wait_zero && !we_q) rdata_q <= mem_dq_i;
    end
  end

  always_comb begin
    row_active = (st_q == ST_IDLE) ? page_open_q
               : (st_q inside {ST_ROW_HOLD, ST_COL_SET, ST_COL_ACT, ST_RSP, ST_REF_ACT});
    unique case (st_q)
      ST_ROW_SET, ST_ROW_HOLD: mem_addr_o = AW'(row_q);
      ST_REF_SET, ST_REF_ACT:  mem_addr_o = AW'(ref_row);
      ST_COL_SET, ST_COL_ACT:  mem_addr_o = AW'(col_q);
      default:                 mem_addr_o = '0;
    endcase
  end

  assign mem_row_sel_n_o = !row_active;
  assign mem_col_sel_n_o = (st_q != ST_COL_ACT);
  assign mem_dq_oe_o     = we_q && (st_q inside {ST_COL_SET, ST_COL_ACT});
  assign mem_we_n_o      = !mem_dq_oe_o;
  assign mem_dq_o        = wdata_q;
  assign rsp_valid_o     = (st_q == ST_RSP) && !we_q;
  assign rsp_rdata_o     = rdata_q;

  // cycles the row strobe has been high, saturating; starts saturated
  logic [HW-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hi_cnt_q <= HW'(PRE_CYC);
    else if (!mem_row_sel_n_o)   hi_cnt_q <= '0;
    else if (hi_cnt_q != HW'(PRE_CYC)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (mem_row_sel_n_o && mem_col_sel_n_o && mem_we_n_o && !rsp_valid_o));
  // R2
  row_addr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_row_sel_n_o) |-> $stable(mem_addr_o));
  // R3
  col_addr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_col_sel_n_o) |-> (!mem_row_sel_n_o && $stable(mem_addr_o)));
  // R4
  write_data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_col_sel_n_o && !mem_we_n_o) |-> $stable(mem_dq_o));
  // R6
  precharge_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_row_sel_n_o) |-> (hi_cnt_q >= HW'(PRE_CYC)));
  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R10
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

// File: tb/sim_page_dram_ctrl.sv
module sim_page_dram_ctrl;
  localparam int ROW_W = 3, COL_W = 3, DATA_W = 8;
  localparam int REF_P = 60, PRE = 2, ACC = 2;
  localparam int AW    = ROW_W + COL_W;
  localparam int WORDS = 1 << AW;
  localparam int ROWS  = 1 << ROW_W;
  localparam int MAXGAP = ROWS * REF_P + 4 * (PRE + ACC + 4);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, row_n, col_n, we_n, dq_oe;
  logic [DATA_W-1:0] rsp_rdata, dq_o, dq_i;
  logic [2:0] mem_addr;

  always #2 clk = ~clk;

  page_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                   .REF_PERIOD(REF_P), .PRE_CYC(PRE), .ACC_CYC(ACC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .mem_addr_o(mem_addr),
    .mem_row_sel_n_o(row_n), .mem_col_sel_n_o(col_n), .mem_we_n_o(we_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // DRAM model
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] exp_mem [WORDS];
  logic [ROW_W-1:0] m_row = '0, exp_ref_row = '0;
  logic [COL_W-1:0] m_col = '0;
  logic p_row_n = 1, p_col_n = 1, m_col_seen = 0;
  int cyc = 0, ref_cnt = 0;
  int last_act [ROWS];
  int max_gap [ROWS];

  assign dq_i = mem[{m_row, m_col}];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_row_n && !row_n) begin
        m_row = mem_addr[ROW_W-1:0];
        m_col_seen = 0;
        last_act[m_row] = cyc;
      end
      if (p_col_n && !col_n) begin
        m_col = mem_addr[COL_W-1:0];
        m_col_seen = 1;
        if (!we_n) mem[{m_row, m_col}] = dq_o;
      end
      if (!p_row_n && row_n && !m_col_seen) begin
        // R8: refresh row sequence
        chk(m_row == exp_ref_row, "R8", m_row, exp_ref_row);
        exp_ref_row = exp_ref_row + 1'b1;
        ref_cnt++;
      end
      for (int r = 0; r < ROWS; r++)
        if (cyc - last_act[r] > max_gap[r]) max_gap[r] = cyc - last_act[r];
    end
    p_row_n = row_n;
    p_col_n = col_n;
  end

  task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
    int lat, exp_lat;
    bit closed, hit;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    closed  = row_n;
    hit     = !closed && (m_row == a[AW-1:COL_W]);
    exp_lat = hit ? ACC + 1 : (closed ? ACC + 3 : ACC + 3 + PRE);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    // R10
    chk(!req_ready, "R10", req_ready, 0);
    if (we) begin
      exp_mem[a] = d;
    end else begin
      lat = 0;
      while (!rsp_valid && lat < 64) begin
        @(posedge clk); lat++; @(negedge clk);
      end
      // R5
      chk(lat == exp_lat, "R5", lat, exp_lat);
      // R4
      chk(rsp_rdata == exp_mem[a], "R4", rsp_rdata, exp_mem[a]);
      @(negedge clk);
      // R9
      chk(!rsp_valid, "R9", rsp_valid, 0);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int a, input int k);
    return DATA_W'(a * 37 + k * 11 + 5);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] lcg;
    for (int i = 0; i < WORDS; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    for (int r = 0; r < ROWS; r++) begin last_act[r] = 0; max_gap[r] = 0; end
    repeat (4) @(negedge clk);
    // R1
    chk(row_n && col_n && we_n && !dq_oe && !rsp_valid, "R1",
        {row_n, col_n, we_n, dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1;
    for (int a = 0; a < WORDS; a++) do_op(1, AW'(a), pat(a, 0));
    for (int a = 0; a < WORDS; a++) do_op(0, AW'(a), '0);
    for (int c = 0; c < (1 << COL_W); c++)
      for (int r = 0; r < ROWS; r++) do_op(0, AW'((r << COL_W) | c), '0);
    lcg = 6'd13;
    for (int k = 0; k < 160; k++) begin
      lcg = lcg * 6'd21 + 6'd17;
      do_op(k % 3 == 0, lcg, pat(lcg, k + 1));
      repeat (k % 4) @(negedge clk);
    end
    repeat (1200) @(negedge clk);
    for (int a = WORDS - 1; a >= 0; a--) do_op(0, AW'(a), '0);
    repeat (20) @(negedge clk);
    // R7
    for (int r = 0; r < ROWS; r++) chk(max_gap[r] <= MAXGAP, "R7", max_gap[r], MAXGAP);
    chk(ref_cnt >= cyc / REF_P - 2, "R7", ref_cnt, cyc / REF_P - 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule